// File: doc/BRIEF.md
# Debug Channel Interrupt Enable Register

This block holds the two enable bits that decide whether the receive and transmit status of a debug communications channel raise one shared interrupt request. The receive path requests service while the receive buffer is full. The transmit path requests service while the transmit buffer is empty. Each path has its own enable, and the two requests are ORed into one registered interrupt line. The raw channel flags are also passed straight through as legacy status outputs. The enables do not gate these outputs.

The block also judges each system-register access to itself. It uses the requester's privilege level (0 to 3) and the debug trap controls held at levels 2 and 3. Each access has exactly one outcome: it is performed, it is flagged as undefined, or it raises a trap. A trap carries a target level, a flag that marks the hypervisor-style trap taken when level 2 runs in 32-bit state, and a fixed syndrome code. The verdict is combinational in the cycle of the request. An accepted write takes effect at the next clock edge.

Top module: `dbgch_irqen_reg`

## Requirements
- R1: Read data places the receive enable at bit 30 and the transmit enable at bit 29. Every other bit reads as 0, and write data in those other bits is ignored.
- R2: When the receive enable is 1 and rx_full is 1, irq_out is 1 one clock later. With the receive enable at 0, rx_full alone never raises irq_out.
- R3: When the transmit enable is 1 and tx_full is 0, irq_out is 1 one clock later. The receive and transmit terms are ORed together.
- R4: Cold reset (rst_n low) clears both enables and irq_out. A warm reset pulse with warm_into_32 at 1 clears both enables. A warm reset pulse with warm_into_32 at 0 leaves them unchanged. A warm reset pulse takes precedence over a write in the same cycle.
- R5: legacy_rx always equals rx_full and legacy_tx always equals tx_full, whatever the enables hold.
- R6: Any access from level 0 gives acc_undef, and the enables are not changed.
- R7: At level 1 the checks apply in this priority. First, level 2 enabled, 64-bit, with either of its two debug trap controls set: trap to level 2 with trap_hyp at 0. Second, level 2 enabled, 32-bit, with either control set: trap to level 2 with trap_hyp at 1. Third, level 3 present, 64-bit, with its debug access trap set: trap to level 3. Otherwise the access is performed.
- R8: At level 2 the access traps to level 3 only when level 3 is present, 64-bit and its debug access trap is set. Otherwise the access is performed.
- R9: Accesses from level 3 are always performed.
- R10: Every trap reports trap_syndrome 0x05. A trapped or undefined access drops its write and drives rd_data to 0. A performed write also returns rd_data 0.
- R11: While req_valid is 1, exactly one of acc_done, acc_undef and acc_trap is 1. While req_valid is 0, none of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, synchronous, active low |
| warm_rst | input | 1 | Warm reset pulse, synchronous, active high |
| warm_into_32 | input | 1 | Core comes out of warm reset in 32-bit state |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lvl | input | 2 | Privilege level of the requester (0..3) |
| req_wdata | input | 32 | Write data |
| lvl2_enabled | input | 1 | Level 2 is enabled |
| lvl2_is_64 | input | 1 | Level 2 runs in 64-bit state |
| lvl2_dbg_route_trap | input | 1 | Level 2 debug-exception routing control |
| lvl2_dbg_acc_trap | input | 1 | Level 2 debug-access trap control |
| lvl3_present | input | 1 | Level 3 is implemented |
| lvl3_is_64 | input | 1 | Level 3 runs in 64-bit state |
| lvl3_dbg_acc_trap | input | 1 | Level 3 debug-access trap control |
| rx_full | input | 1 | Channel receive buffer full |
| tx_full | input | 1 | Channel transmit buffer full |
| rd_data | output | 32 | Read data of a performed read, else 0 |
| acc_done | output | 1 | Access performed |
| acc_undef | output | 1 | Access is undefined |
| acc_trap | output | 1 | Access traps |
| trap_lvl | output | 2 | Target level of the trap |
| trap_hyp | output | 1 | Trap is the hypervisor-style trap |
| trap_syndrome | output | 6 | Exception class code of the trap |
| irq_out | output | 1 | Combined registered interrupt request |
| legacy_rx | output | 1 | Raw receive-full status |
| legacy_tx | output | 1 | Raw transmit-full status |

## Verification
The properties assume a synchronous environment. Request and trap-control inputs are stable around each rising edge, and req_lvl always holds a defined level. The write-drop property also assumes that no warm reset pulse coincides with the dropped write. The bench changes every input only after a falling edge, keeps the trap controls fixed for the whole of each access, and never pulses warm reset during an access.

// File: rtl/dbgch_pkg.sv
package dbgch_pkg;

    typedef enum logic [2:0] {
        VERD_IDLE,
        VERD_DONE,
        VERD_UNDEF,
        VERD_TRAP_L2,
        VERD_TRAP_HYP,
        VERD_TRAP_L3
    } verdict_e;

    typedef struct packed {
        logic rx_en;
        logic tx_en;
        logic irq;
    } en_state_t;

    localparam logic [1:0] LVL_USER = 2'd0;
    localparam logic [1:0] LVL_KERN = 2'd1;
    localparam logic [1:0] LVL_HYPV = 2'd2;
    localparam logic [1:0] LVL_MON  = 2'd3;

endpackage

// File: rtl/dbgch_access_gate.sv
module dbgch_access_gate
    import dbgch_pkg::*;
(
    input  logic       req_valid,
    input  logic [1:0] req_lvl,
    input  logic       lvl2_enabled,
    input  logic       lvl2_is_64,
    input  logic       lvl2_dbg_route_trap,
    input  logic       lvl2_dbg_acc_trap,
    input  logic       lvl3_present,
    input  logic       lvl3_is_64,
    input  logic       lvl3_dbg_acc_trap,
    output verdict_e   verdict
);

    logic l2_hit;
    logic l3_hit;

    always_comb begin
        l2_hit = lvl2_enabled & (lvl2_dbg_route_trap | lvl2_dbg_acc_trap);
        l3_hit = lvl3_present & lvl3_is_64 & lvl3_dbg_acc_trap;
    end

    // Priority chain per requesting level
    always_comb begin
        verdict = VERD_IDLE;
        if (req_valid) begin
            unique case (req_lvl)
                LVL_USER: verdict = VERD_UNDEF;
                LVL_KERN: begin
                    if (l2_hit && lvl2_is_64)       verdict = VERD_TRAP_L2;
                    else if (l2_hit && !lvl2_is_64) verdict = VERD_TRAP_HYP;
                    else if (l3_hit)                verdict = VERD_TRAP_L3;
                    else                            verdict = VERD_DONE;
                end
                LVL_HYPV: verdict = l3_hit ? VERD_TRAP_L3 : VERD_DONE;
                default:  verdict = VERD_DONE;
            endcase
        end
    end

endmodule

// File: rtl/dbgch_verdict_encode.sv
module dbgch_verdict_encode
    import dbgch_pkg::*;
#(
    parameter int unsigned              EC_W    = 6,
    parameter logic [EC_W-1:0]          EC_CODE = 6'h05
) (
    input  verdict_e        verdict,
    output logic            acc_done,
    output logic            acc_undef,
    output logic            acc_trap,
    output logic [1:0]      trap_lvl,
    output logic            trap_hyp,
    output logic [EC_W-1:0] trap_syndrome
);

    always_comb begin
        acc_done      = 1'b0;
        acc_undef     = 1'b0;
        acc_trap      = 1'b0;
        trap_lvl      = 2'd0;
        trap_hyp      = 1'b0;
        trap_syndrome = '0;
        unique case (verdict)
            VERD_DONE:  acc_done  = 1'b1;
            VERD_UNDEF: acc_undef = 1'b1;
            VERD_TRAP_L2: begin
                acc_trap      = 1'b1;
                trap_lvl      = LVL_HYPV;
                trap_syndrome = EC_CODE;
            end
            VERD_TRAP_HYP: begin
                acc_trap      = 1'b1;
                trap_lvl      = LVL_HYPV;
                trap_hyp      = 1'b1;
                trap_syndrome = EC_CODE;
            end
            VERD_TRAP_L3: begin
                acc_trap      = 1'b1;
                trap_lvl      = LVL_MON;
                trap_syndrome = EC_CODE;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dbgch_enable_state.sv
module dbgch_enable_state
    import dbgch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic warm_rst,
    input  logic warm_into_32,
    input  logic wr_en,
    input  logic wr_rx,
    input  logic wr_tx,
    input  logic rx_full,
    input  logic tx_full,
    output logic rx_en,
    output logic tx_en,
    output logic irq
);

    en_state_t st_d;
    en_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (warm_rst) begin
            if (warm_into_32) begin
                st_d.rx_en = 1'b0;
                st_d.tx_en = 1'b0;
            end
        end else if (wr_en) begin
            st_d.rx_en = wr_rx;
            st_d.tx_en = wr_tx;
        end
        st_d.irq = (st_q.rx_en & rx_full) | (st_q.tx_en & ~tx_full);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_en = st_q.rx_en;
    assign tx_en = st_q.tx_en;
    assign irq   = st_q.irq;

endmodule

// File: rtl/dbgch_irqen_reg.sv
module dbgch_irqen_reg
    import dbgch_pkg::*;
#(
    parameter int unsigned     DATA_W  = 32,
    parameter int unsigned     RX_BIT  = 30,
    parameter int unsigned     TX_BIT  = 29,
    parameter int unsigned     EC_W    = 6,
    parameter logic [EC_W-1:0] EC_CODE = 6'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              warm_into_32,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_lvl,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              lvl2_enabled,
    input  logic              lvl2_is_64,
    input  logic              lvl2_dbg_route_trap,
    input  logic              lvl2_dbg_acc_trap,
    input  logic              lvl3_present,
    input  logic              lvl3_is_64,
    input  logic              lvl3_dbg_acc_trap,
    input  logic              rx_full,
    input  logic              tx_full,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_done,
    output logic              acc_undef,
    output logic              acc_trap,
    output logic [1:0]        trap_lvl,
    output logic              trap_hyp,
    output logic [EC_W-1:0]   trap_syndrome,
    output logic              irq_out,
    output logic              legacy_rx,
    output logic              legacy_tx
);

    localparam logic [DATA_W-1:0] RX_SEL = DATA_W'(1) << RX_BIT;
    localparam logic [DATA_W-1:0] TX_SEL = DATA_W'(1) << TX_BIT;

    verdict_e          verdict;
    logic              rx_en;
    logic              tx_en;
    logic              wr_go;
    logic              wr_rx;
    logic              wr_tx;
    logic [DATA_W-1:0] field_word;

    dbgch_access_gate gate_i (
        .req_valid           (req_valid),
        .req_lvl             (req_lvl),
        .lvl2_enabled        (lvl2_enabled),
        .lvl2_is_64          (lvl2_is_64),
        .lvl2_dbg_route_trap (lvl2_dbg_route_trap),
        .lvl2_dbg_acc_trap   (lvl2_dbg_acc_trap),
        .lvl3_present        (lvl3_present),
        .lvl3_is_64          (lvl3_is_64),
        .lvl3_dbg_acc_trap   (lvl3_dbg_acc_trap),
        .verdict             (verdict)
    );

    dbgch_verdict_encode #(
        .EC_W    (EC_W),
        .EC_CODE (EC_CODE)
    ) enc_i (
        .verdict       (verdict),
        .acc_done      (acc_done),
        .acc_undef     (acc_undef),
        .acc_trap      (acc_trap),
        .trap_lvl      (trap_lvl),
        .trap_hyp      (trap_hyp),
        .trap_syndrome (trap_syndrome)
    );

    // Only the two enable positions of the write word matter
    always_comb begin
        wr_go = acc_done & req_write;
        wr_rx = |(req_wdata & RX_SEL);
        wr_tx = |(req_wdata & TX_SEL);
    end

    dbgch_enable_state state_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .warm_rst     (warm_rst),
        .warm_into_32 (warm_into_32),
        .wr_en        (wr_go),
        .wr_rx        (wr_rx),
        .wr_tx        (wr_tx),
        .rx_full      (rx_full),
        .tx_full      (tx_full),
        .rx_en        (rx_en),
        .tx_en        (tx_en),
        .irq          (irq_out)
    );

    for (genvar b = 0; b < DATA_W; b++) begin : g_field
        if (b == RX_BIT) begin : g_rx
            assign field_word[b] = rx_en;
        end else if (b == TX_BIT) begin : g_tx
            assign field_word[b] = tx_en;
        end else begin : g_zero
            assign field_word[b] = 1'b0;
        end
    end

    assign rd_data   = (acc_done && !req_write) ? field_word : '0;
    assign legacy_rx = rx_full;
    assign legacy_tx = tx_full;

endmodule

// File: rtl/dbgch_irqen_chk.sv
module dbgch_irqen_chk #(
    parameter int unsigned     DATA_W  = 32,
    parameter int unsigned     RX_BIT  = 30,
    parameter int unsigned     TX_BIT  = 29,
    parameter int unsigned     EC_W    = 6,
    parameter logic [EC_W-1:0] EC_CODE = 6'h05
) (
    input logic              clk,
    input logic              rst_n,
    input logic              warm_rst,
    input logic              warm_into_32,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_lvl,
    input logic              lvl2_enabled,
    input logic              lvl2_is_64,
    input logic              lvl2_dbg_route_trap,
    input logic              lvl2_dbg_acc_trap,
    input logic              rx_full,
    input logic              tx_full,
    input logic [DATA_W-1:0] rd_data,
    input logic              acc_done,
    input logic              acc_undef,
    input logic              acc_trap,
    input logic [1:0]        trap_lvl,
    input logic              trap_hyp,
    input logic [EC_W-1:0]   trap_syndrome,
    input logic              irq_out,
    input logic              legacy_rx,
    input logic              legacy_tx,
    input logic              rx_en,
    input logic              tx_en
);

    localparam logic [DATA_W-1:0] FIELD_MASK = (DATA_W'(1) << RX_BIT) | (DATA_W'(1) << TX_BIT);

    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~FIELD_MASK) == '0);

    a_r2_r3_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out == ($past(rx_en && rx_full) || $past(tx_en && !tx_full)));

    a_r4_warm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst && warm_into_32 |=> !rx_en && !tx_en);

    a_r5_legacy_raw: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_rx == rx_full && legacy_tx == tx_full);

    a_r6_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_lvl == 2'd0 |-> acc_undef);

    a_r6_r10_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && !acc_done && !warm_rst |=> $stable({rx_en, tx_en}));

    a_r7_l2_64_first: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_lvl == 2'd1 && lvl2_enabled && lvl2_is_64
            && (lvl2_dbg_route_trap || lvl2_dbg_acc_trap)
        |-> acc_trap && trap_lvl == 2'd2 && !trap_hyp);

    a_r9_mon_done: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_lvl == 2'd3 |-> acc_done);

    a_r10_syndrome: assert property (@(posedge clk) disable iff (!rst_n)
        acc_trap |-> trap_syndrome == EC_CODE);

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot({acc_done, acc_undef, acc_trap}));

    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(acc_done || acc_undef || acc_trap));

endmodule

bind dbgch_irqen_reg dbgch_irqen_chk #(
    .DATA_W  (DATA_W),
    .RX_BIT  (RX_BIT),
    .TX_BIT  (TX_BIT),
    .EC_W    (EC_W),
    .EC_CODE (EC_CODE)
) chk_i (
    .clk                 (clk),
    .rst_n               (rst_n),
    .warm_rst            (warm_rst),
    .warm_into_32        (warm_into_32),
    .req_valid           (req_valid),
    .req_write           (req_write),
    .req_lvl             (req_lvl),
    .lvl2_enabled        (lvl2_enabled),
    .lvl2_is_64          (lvl2_is_64),
    .lvl2_dbg_route_trap (lvl2_dbg_route_trap),
    .lvl2_dbg_acc_trap   (lvl2_dbg_acc_trap),
    .rx_full             (rx_full),
    .tx_full             (tx_full),
    .rd_data             (rd_data),
    .acc_done            (acc_done),
    .acc_undef           (acc_undef),
    .acc_trap            (acc_trap),
    .trap_lvl            (trap_lvl),
    .trap_hyp            (trap_hyp),
    .trap_syndrome       (trap_syndrome),
    .irq_out             (irq_out),
    .legacy_rx           (legacy_rx),
    .legacy_tx           (legacy_tx),
    .rx_en               (rx_en),
    .tx_en               (tx_en)
);

// File: tb/dbgch_irqen_reg_tb_top.sv
module dbgch_irqen_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        warm_into_32 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_lvl = 2'd0;
    logic [31:0] req_wdata = '0;
    logic        lvl2_enabled = 1'b0;
    logic        lvl2_is_64 = 1'b0;
    logic        lvl2_dbg_route_trap = 1'b0;
    logic        lvl2_dbg_acc_trap = 1'b0;
    logic        lvl3_present = 1'b0;
    logic        lvl3_is_64 = 1'b0;
    logic        lvl3_dbg_acc_trap = 1'b0;
    logic        rx_full = 1'b0;
    logic        tx_full = 1'b1;
    logic [31:0] rd_data;
    logic        acc_done, acc_undef, acc_trap, trap_hyp;
    logic [1:0]  trap_lvl;
    logic [5:0]  trap_syndrome;
    logic        irq_out, legacy_rx, legacy_tx;

    int n_chk  = 0;
    int n_fail = 0;

    logic        c_done, c_undef, c_trap, c_hyp;
    logic [1:0]  c_lvl;
    logic [5:0]  c_syn;
    logic [31:0] c_rd;

    always #5 clk = ~clk;

    dbgch_irqen_reg dut_i (
        .clk (clk), .rst_n (rst_n), .warm_rst (warm_rst), .warm_into_32 (warm_into_32),
        .req_valid (req_valid), .req_write (req_write), .req_lvl (req_lvl),
        .req_wdata (req_wdata), .lvl2_enabled (lvl2_enabled), .lvl2_is_64 (lvl2_is_64),
        .lvl2_dbg_route_trap (lvl2_dbg_route_trap), .lvl2_dbg_acc_trap (lvl2_dbg_acc_trap),
        .lvl3_present (lvl3_present), .lvl3_is_64 (lvl3_is_64),
        .lvl3_dbg_acc_trap (lvl3_dbg_acc_trap), .rx_full (rx_full), .tx_full (tx_full),
        .rd_data (rd_data), .acc_done (acc_done), .acc_undef (acc_undef),
        .acc_trap (acc_trap), .trap_lvl (trap_lvl), .trap_hyp (trap_hyp),
        .trap_syndrome (trap_syndrome), .irq_out (irq_out),
        .legacy_rx (legacy_rx), .legacy_tx (legacy_tx)
    );

    // {lvl[1:0], l2en, l2_64, route, acc2, l3p, l3_64, acc3, outcome[2:0]}
    // outcome: 0 done, 1 undef, 2 trap l2, 3 hyp trap, 4 trap l3
    localparam int NV = 16;
    localparam logic [11:0] VEC [NV] = '{
        {2'd0, 7'b0000000, 3'd1},
        {2'd0, 7'b1111111, 3'd1},
        {2'd1, 7'b0000000, 3'd0},
        {2'd1, 7'b1110000, 3'd2},
        {2'd1, 7'b1101111, 3'd2},
        {2'd1, 7'b1010000, 3'd3},
        {2'd1, 7'b1001111, 3'd3},
        {2'd1, 7'b0111000, 3'd0},
        {2'd1, 7'b0000111, 3'd4},
        {2'd1, 7'b0000101, 3'd0},
        {2'd1, 7'b0000011, 3'd0},
        {2'd2, 7'b1111000, 3'd0},
        {2'd2, 7'b0000111, 3'd4},
        {2'd2, 7'b1111101, 3'd0},
        {2'd3, 7'b1111111, 3'd0},
        {2'd1, 7'b1100111, 3'd4}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] lvl, input logic wr, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_lvl = lvl; req_write = wr; req_wdata = wd;
        #2;
        c_done = acc_done; c_undef = acc_undef; c_trap = acc_trap;
        c_hyp = trap_hyp; c_lvl = trap_lvl; c_syn = trap_syndrome; c_rd = rd_data;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic set_ctrl(input logic [6:0] c);
        {lvl2_enabled, lvl2_is_64, lvl2_dbg_route_trap, lvl2_dbg_acc_trap,
         lvl3_present, lvl3_is_64, lvl3_dbg_acc_trap} = c;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: cold reset state
        chk("R4 irq after cold reset", {31'd0, irq_out}, 32'd0);
        acc(2'd3, 1'b0, '0);
        chk("R4 enables after cold reset", c_rd, 32'd0);

        // R11: idle request gives no outcome
        #2;
        chk("R11 idle outcome", {29'd0, acc_done, acc_undef, acc_trap}, 32'd0);

        // R1: field placement and reserved bits
        acc(2'd3, 1'b1, 32'hFFFF_FFFF);
        chk("R10 write returns zero", c_rd, 32'd0);
        acc(2'd3, 1'b0, '0);
        chk("R1 all-ones write", c_rd, 32'h6000_0000);
        acc(2'd3, 1'b1, 32'h9FFF_FFFF);
        acc(2'd3, 1'b0, '0);
        chk("R1 reserved-only write", c_rd, 32'd0);
        acc(2'd3, 1'b1, 32'h4000_0000);
        acc(2'd3, 1'b0, '0);
        chk("R1 receive bit only", c_rd, 32'h4000_0000);

        // R2: receive path, one-cycle latency
        rx_full = 1'b1; tx_full = 1'b1;
        @(posedge clk); #1;
        chk("R2 rx irq set", {31'd0, irq_out}, 32'd1);
        @(negedge clk); rx_full = 1'b0; #2;
        chk("R2 irq holds before edge", {31'd0, irq_out}, 32'd1);
        @(posedge clk); #1;
        chk("R2 rx irq clear", {31'd0, irq_out}, 32'd0);

        // R3: transmit path, receive gated off
        acc(2'd3, 1'b1, 32'h2000_0000);
        rx_full = 1'b1;
        chk("R3 irq before enable reaches", {31'd0, irq_out}, 32'd0);
        @(posedge clk); #1;
        chk("R2 rx gated by enable", {31'd0, irq_out}, 32'd0);
        @(negedge clk); tx_full = 1'b0;
        @(posedge clk); #1;
        chk("R3 tx empty irq", {31'd0, irq_out}, 32'd1);
        @(negedge clk); tx_full = 1'b1;
        @(posedge clk); #1;
        chk("R3 tx full no irq", {31'd0, irq_out}, 32'd0);

        // R5: legacy flags raw with enables off
        acc(2'd3, 1'b1, 32'd0);
        @(negedge clk); rx_full = 1'b1; tx_full = 1'b0; #2;
        chk("R5 legacy flags", {30'd0, legacy_rx, legacy_tx}, 32'd2);
        @(posedge clk); #1;
        chk("R5 irq stays low", {31'd0, irq_out}, 32'd0);
        @(negedge clk); rx_full = 1'b0; tx_full = 1'b1; #2;
        chk("R5 legacy flags swapped", {30'd0, legacy_rx, legacy_tx}, 32'd1);

        // R4: warm reset variants
        acc(2'd3, 1'b1, 32'h6000_0000);
        @(negedge clk); warm_rst = 1'b1; warm_into_32 = 1'b0;
        @(negedge clk); warm_rst = 1'b0;
        acc(2'd3, 1'b0, '0);
        chk("R4 warm reset 64-bit holds", c_rd, 32'h6000_0000);
        @(negedge clk); warm_rst = 1'b1; warm_into_32 = 1'b1;
        @(negedge clk); warm_rst = 1'b0; warm_into_32 = 1'b0;
        acc(2'd3, 1'b0, '0);
        chk("R4 warm reset 32-bit clears", c_rd, 32'd0);

        // R6..R11: access verdict table
        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            logic [2:0]  o;
            v = VEC[i];
            o = v[2:0];
            set_ctrl(7'd0);
            acc(2'd3, 1'b1, 32'h6000_0000);
            set_ctrl(v[9:3]);
            acc(v[11:10], 1'b0, '0);
            chk($sformatf("R11 outcome vec %0d", i), {29'd0, c_done, c_undef, c_trap},
                {29'd0, o == 3'd0, o == 3'd1, o >= 3'd2});
            chk($sformatf("R7 R8 trap level vec %0d", i), {30'd0, c_lvl},
                {30'd0, (o == 3'd2 || o == 3'd3) ? 2'd2 : (o == 3'd4 ? 2'd3 : 2'd0)});
            chk($sformatf("R7 hyp flag vec %0d", i), {31'd0, c_hyp}, {31'd0, o == 3'd3});
            chk($sformatf("R10 syndrome vec %0d", i), {26'd0, c_syn},
                (o >= 3'd2) ? 32'h05 : 32'h00);
            chk($sformatf("R10 read data vec %0d", i), c_rd,
                (o == 3'd0) ? 32'h6000_0000 : 32'd0);
            acc(v[11:10], 1'b1, 32'd0);
            set_ctrl(7'd0);
            acc(2'd3, 1'b0, '0);
            chk($sformatf("R6 R9 write effect vec %0d", i), c_rd,
                (o == 3'd0) ? 32'd0 : 32'h6000_0000);
        end

        summary();
        $finish;
    end

endmodule